// File: doc/BRIEF.md
# Ethernet PHY Basic Status Register

This block is the basic status word of a 10/100 Ethernet transceiver as seen from the management port. It combines fixed capability flags, one software-writable control flag and three status flags with memory. The memory flags are link-up, jabber and remote fault. It samples the live indications from the link monitor, the jabber detector, the auto-negotiation engine and the partner-ability fault bit every cycle.

A management read is a one-cycle strobe. The word shown during that cycle holds the values captured so far. On the following edge the memory flags are refreshed from the live inputs. A link drop therefore stays visible until software has seen it, and a jabber or remote-fault event stays visible until software has seen it. An event that arrives in the same cycle as the read is never lost. Only the preamble-suppression flag accepts writes.

Top module: `phy_basic_status`

## Requirements
- R1: The read word has bit 15 = 0, bits 14, 13, 12 and 11 = 1, bit 3 = 1 and bit 0 = 1 at all times.
- R2: Bits 10:7 of the read word are always 0, whatever the write data.
- R3: Bit 6 (preamble suppression) resets to 1. A write strobe loads `wr_data_i[6]` into it, and the new value is visible the cycle after the strobe. `preamble_sup_o` carries the same value.
- R4: Bit 5 (auto-negotiation complete) resets to 0 and shows `an_done_i` as sampled on the previous clock edge.
- R5: Bit 4 (remote fault) becomes 1 the cycle after `lp_rfault_i` is 1. It then stays 1 until a read strobe has been given.
- R6: Bit 2 (link status) becomes 0 the cycle after `link_up_i` is 0. It then stays 0 until a read strobe has been given, even if the link returns.
- R7: Bit 1 (jabber) becomes 1 the cycle after `jabber_i` and `speed_10_i` are both 1, and then stays 1 until a read strobe. Jabber while `speed_10_i` is 0 has no effect.
- R8: During a read strobe the word shows the held values. On the next cycle bits 4, 2 and 1 equal the live conditions that were present during the strobe.
- R9: A fault, jabber or link-drop event in the same cycle as a read strobe is kept. The affected bit reads 1 (bits 4 and 1) or 0 (bit 2) on the next cycle.
- R10: After reset, bits 4, 2 and 1 read 0, and the whole word reads 0x7849.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | One-cycle read strobe for this register |
| wr_stb_i | input | 1 | One-cycle write strobe for this register |
| wr_data_i | input | 16 | Write data; only bit 6 is used |
| link_up_i | input | 1 | Live link-valid indication |
| jabber_i | input | 1 | Live jabber condition |
| speed_10_i | input | 1 | 1 when operating at 10 Mbps |
| an_done_i | input | 1 | Auto-negotiation complete from the negotiation engine |
| lp_rfault_i | input | 1 | Remote-fault bit of the partner ability word |
| rd_data_o | output | 16 | Current register value |
| preamble_sup_o | output | 1 | Preamble-suppression enable for the frame decoder |

## Verification
Every status input and every write affects the read word exactly one clock edge later, through a single register. The clear that a read causes also appears one edge later. The bench drives inputs at the falling edge and compares the word one nanosecond after that, before the next rising edge. It updates its own expected state only at that rising edge, so the word seen during a read strobe is always compared against the values held before the strobe. A long pseudo-random sweep covers all input combinations, with and without reads. Directed sequences then check link recovery without a read, collisions between events and reads, and writes to the reserved field.

// File: rtl/phy_bsr_pkg.sv
package phy_bsr_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned BIT_PSUP = 6;
  localparam int unsigned BIT_ANC  = 5;
  localparam int unsigned BIT_RF   = 4;
  localparam int unsigned BIT_LINK = 2;
  localparam int unsigned BIT_JAB  = 1;
  // fixed capability pattern: T4=0, TX/10T FD+HD=1, AN ability=1, ext cap=1
  localparam logic [REG_W-1:0] CAP_MASK = 16'h7809;
endpackage

// File: rtl/stat_latch.sv
module stat_latch #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  generate
    if (LATCH_HIGH) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    q_q <= 1'b0;
        else if (clr_i) q_q <= live_i;
        else            q_q <= q_q | live_i;

      // R9
      hi_event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_i |=> q_q);
      // R5
      hi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q && !clr_i) |=> q_q);
    end else begin : g_lo
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    q_q <= 1'b0;
        else if (clr_i) q_q <= live_i;
        else            q_q <= q_q & live_i;

      // R9
      lo_event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !live_i |=> !q_q);
      // R6
      lo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q_q && !clr_i) |=> !q_q);
    end
  endgenerate

  assign q_o = q_q;
endmodule

// File: rtl/ctl_bit.sv
module ctl_bit #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   q_q <= RST_VAL;
    else if (we_i) q_q <= d_i;

  // R3
  ctl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_q == $past(d_i)));
  // R3
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_q));

  assign q_o = q_q;
endmodule

// File: rtl/phy_basic_status.sv
module phy_basic_status
  import phy_bsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_stb_i,
  input  logic             wr_stb_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             link_up_i,
  input  logic             jabber_i,
  input  logic             speed_10_i,
  input  logic             an_done_i,
  input  logic             lp_rfault_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             preamble_sup_o
);
  logic psup, anc_q, rf, link, jab;
  logic jab_live;
  logic unused_wr;

  assign jab_live  = jabber_i & speed_10_i;
  assign unused_wr = ^{wr_data_i[REG_W-1:BIT_PSUP+1], wr_data_i[BIT_PSUP-1:0]};

  ctl_bit #(.RST_VAL(1'b1)) u_psup (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_stb_i),
    .d_i(wr_data_i[BIT_PSUP]), .q_o(psup));

  stat_latch #(.LATCH_HIGH(1'b1)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(lp_rfault_i),
    .clr_i(rd_stb_i), .q_o(rf));

  stat_latch #(.LATCH_HIGH(1'b0)) u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(link_up_i),
    .clr_i(rd_stb_i), .q_o(link));

  stat_latch #(.LATCH_HIGH(1'b1)) u_jab (
    .clk_i(clk_i), .rst_ni(rst_ni), .live_i(jab_live),
    .clr_i(rd_stb_i), .q_o(jab));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) anc_q <= 1'b0;
    else         anc_q <= an_done_i;

  always_comb begin
    rd_data_o           = CAP_MASK;
    rd_data_o[BIT_PSUP] = psup;
    rd_data_o[BIT_ANC]  = anc_q;
    rd_data_o[BIT_RF]   = rf;
    rd_data_o[BIT_LINK] = link;
    rd_data_o[BIT_JAB]  = jab;
  end

  assign preamble_sup_o = psup;

  // R4
  anc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_data_o[BIT_ANC] == $past(an_done_i)));
  // R7
  jab_fast_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !speed_10_i) |=> !rd_data_o[BIT_JAB]);
  // R8
  link_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> (rd_data_o[BIT_LINK] == $past(link_up_i)));
  // R3
  psup_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> (preamble_sup_o == $past(wr_data_i[BIT_PSUP])));
endmodule

// File: tb/phy_basic_status_tb.sv
module phy_basic_status_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_stb_i = 0, wr_stb_i = 0;
  logic [15:0] wr_data_i = '0;
  logic link_up_i = 0, jabber_i = 0, speed_10_i = 0, an_done_i = 0, lp_rfault_i = 0;
  logic [15:0] rd_data_o;
  logic preamble_sup_o;

  int n_chk = 0, n_fail = 0;
  logic e_pre, e_an, e_rf, e_link, e_jab;
  logic [15:0] lfsr;

  always #4 clk = ~clk;

  phy_basic_status dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i),
    .wr_data_i(wr_data_i), .link_up_i(link_up_i), .jabber_i(jabber_i),
    .speed_10_i(speed_10_i), .an_done_i(an_done_i), .lp_rfault_i(lp_rfault_i),
    .rd_data_o(rd_data_o), .preamble_sup_o(preamble_sup_o));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, compare before next posedge, advance model at posedge
  task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                      input logic lk, input logic jb, input logic s10,
                      input logic rf, input logic an);
    rd_stb_i = rd; wr_stb_i = wr; wr_data_i = wd;
    link_up_i = lk; jabber_i = jb; speed_10_i = s10; lp_rfault_i = rf; an_done_i = an;
    #1;
    chk("R1", rd_data_o & 16'hF809, 16'h7809);
    chk("R2", rd_data_o & 16'h0780, 16'h0000);
    chk("R3", {15'd0, rd_data_o[6]}, {15'd0, e_pre});
    chk("R3", {15'd0, preamble_sup_o}, {15'd0, e_pre});
    chk("R4", {15'd0, rd_data_o[5]}, {15'd0, e_an});
    chk("R5", {15'd0, rd_data_o[4]}, {15'd0, e_rf});
    chk("R6", {15'd0, rd_data_o[2]}, {15'd0, e_link});
    chk("R7", {15'd0, rd_data_o[1]}, {15'd0, e_jab});
    @(posedge clk);
    e_rf   = rd ? rf : (e_rf | rf);
    e_jab  = rd ? (jb & s10) : (e_jab | (jb & s10));
    e_link = rd ? lk : (e_link & lk);
    e_an   = an;
    if (wr) e_pre = wd[6];
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    e_pre = 1; e_an = 0; e_rf = 0; e_link = 0; e_jab = 0;
    #20;
    @(negedge clk);
    chk("R10", rd_data_o, 16'h7849);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", rd_data_o, 16'h7849);

    // R6: link stays low until read even when the link comes back
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6", {15'd0, rd_data_o[2]}, 16'd0);
    step(1, 0, 0, 1, 0, 0, 0, 0);   // R8: strobe cycle shows the held 0
    chk("R8", {15'd0, rd_data_o[2]}, 16'd1);
    step(0, 0, 0, 0, 0, 0, 0, 0);   // drop one cycle
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6", {15'd0, rd_data_o[2]}, 16'd0);
    // R9: link drop on the read cycle is kept
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", {15'd0, rd_data_o[2]}, 16'd0);

    // R7: jabber at 100 Mbps ignored, at 10 Mbps latched
    step(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R7", {15'd0, rd_data_o[1]}, 16'd0);
    step(0, 0, 0, 1, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 1, 0, 0);
    chk("R7", {15'd0, rd_data_o[1]}, 16'd1);
    // R9: jabber and fault on the read cycle stay set
    step(1, 0, 0, 1, 1, 1, 1, 0);
    chk("R9", rd_data_o & 16'h0012, 16'h0012);
    step(1, 0, 0, 1, 0, 1, 0, 0);
    chk("R8", rd_data_o & 16'h0016, 16'h0004);

    // R2/R3: writes touch only bit 6
    step(0, 1, 16'hFFBF, 1, 0, 0, 0, 1);
    chk("R3", {15'd0, preamble_sup_o}, 16'd0);
    chk("R2", rd_data_o & 16'h0780, 16'h0000);
    step(0, 1, 16'h0040, 1, 0, 0, 0, 1);
    chk("R3", {15'd0, preamble_sup_o}, 16'd1);
    step(0, 1, 16'h0780, 1, 0, 0, 0, 0);
    chk("R2", rd_data_o & 16'h07C0, 16'h0000);

    // sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2], lfsr[4] & lfsr[5], {lfsr[7:0], lfsr[15:8]},
           lfsr[0] | lfsr[1], lfsr[6], lfsr[8], lfsr[9] & lfsr[11], lfsr[12]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule